// File: doc/BRIEF.md
# Register-Controlled Pulse-Width Modulator

This block produces one pulse-width-modulated output from a single 32-bit control word. The control word is written and read through a simple synchronous port with per-byte write strobes. Each PWM period is split into 256 steps. Every step lasts a programmable number of input clock cycles, called the step length. At the start of each period the output is low for a programmable number of steps, called the low count, and it is high for the rest of the period.

When the block is switched off, the output is driven to a programmable idle level and all internal counters stay at zero. Software can change the step length and the low count while the block runs. It does this by writing only the two low bytes, which leaves the run and idle-level bits as they were. New timing values are picked up only at a period boundary.

Top module: `pwm_reg_gen`

## Requirements
- R1: After reset, the control word reads 0x00000000 and `pwm_o` is low.
- R2: The control word has these fields: bit 31 is run, bit 30 is idle level, bits 15:8 are the step length, and bits 7:0 are the low count. Bits 29:16 always read as zero. Byte strobe `wr_be_i[k]` writes bits 8k+7:8k. `rd_data_o` shows the stored word in the cycle after the write edge.
- R3: While run is 0, `pwm_o` equals the idle-level bit, and the prescaler and step counter are held at zero.
- R4: Each step lasts L input cycles, where L is the step length. A step length of 0 means 256, so one period lasts 256·L cycles.
- R5: Within a period, the output is low for the first N steps and high for the remaining 256−N steps, where N is the low count. N = 0 gives a high output for the whole period, and N = 255 gives exactly one high step.
- R6: When run goes from 0 to 1, step 0 of a new period begins in the cycle right after that write edge.
- R7: If the step length or low count is written while the block runs, the period in progress keeps the old values. The new values apply from the next period onward.
- R8: A write with `wr_be_i[3]` = 0 leaves the run and idle-level bits unchanged, and the block keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data |
| wr_be_i | input | 4 | Byte write enables |
| rd_data_o | output | 32 | Current control word |
| pwm_o | output | 1 | Modulated output |

## Verification
A write reaches `rd_data_o` and `pwm_o` at the first falling edge after the rising edge that captures it. That falling edge is cycle c = 0 of the new state. A run-enabling write starts step 0 at c = 0, and the expected output at cycle c is low exactly when floor(c/L) mod 256 is less than N.

The bench drives every input at a falling edge and samples at the next falling edge, keeping a cycle index c from the last enabling write. For mid-period writes it switches to the new L and N in its reference only from c = 256·L_old onward. The check also covers the step length 0 case, running through one complete 65,536-cycle period and into the next.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LANES    = WORD_W / 8;
  localparam int unsigned STEP_W   = 8;   // 2**STEP_W steps per period
  localparam int unsigned DIV_W    = 8;   // step length field width
  localparam int unsigned RUN_BIT  = 31;
  localparam int unsigned IDLE_BIT = 30;
  localparam int unsigned DIV_LSB  = 8;
  localparam int unsigned LOW_LSB  = 0;
  localparam int unsigned RSV_LSB  = DIV_LSB + DIV_W;
  localparam int unsigned RSV_MSB  = IDLE_BIT - 1;

  typedef struct packed {
    logic              run;
    logic              idle;
    logic [DIV_W-1:0]  div;
    logic [STEP_W-1:0] low;
  } cfg_t;
endpackage

// File: rtl/pwm_cfg_reg.sv
module pwm_cfg_reg
  import pwm_gen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [LANES-1:0]  wr_be_i,
  output cfg_t              cfg_q_o,
  output cfg_t              cfg_d_o,
  output logic [WORD_W-1:0] rd_data_o
);
  cfg_t              cfg_q;
  logic [WORD_W-1:0] cur_w, mrg_w;
  logic              unused_rsv;

  always_comb begin
    cur_w                       = '0;
    cur_w[RUN_BIT]              = cfg_q.run;
    cur_w[IDLE_BIT]             = cfg_q.idle;
    cur_w[DIV_LSB +: DIV_W]     = cfg_q.div;
    cur_w[LOW_LSB +: STEP_W]    = cfg_q.low;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mrg_w[8*g +: 8] = (wr_en_i && wr_be_i[g]) ? wr_data_i[8*g +: 8]
                                                     : cur_w[8*g +: 8];
  end

  assign unused_rsv = ^mrg_w[RSV_MSB:RSV_LSB];

  assign cfg_d_o.run  = mrg_w[RUN_BIT];
  assign cfg_d_o.idle = mrg_w[IDLE_BIT];
  assign cfg_d_o.div  = mrg_w[DIV_LSB +: DIV_W];
  assign cfg_d_o.low  = mrg_w[LOW_LSB +: STEP_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d_o;
  end

  assign cfg_q_o   = cfg_q;
  assign rd_data_o = cur_w;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, last;

  // div 0 wraps to all ones, i.e. a length of 2**DIV_W
  assign last   = div_i - DIV_W'(1);
  assign tick_o = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_period_seq.sv
module pwm_period_seq #(
  parameter int unsigned STEP_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [DIV_W-1:0]  start_div_i,   // taken while cleared
  input  logic [STEP_W-1:0] start_low_i,
  input  logic [DIV_W-1:0]  live_div_i,    // taken at period wrap
  input  logic [STEP_W-1:0] live_low_i,
  output logic [STEP_W-1:0] step_o,
  output logic [DIV_W-1:0]  div_sh_o,
  output logic [STEP_W-1:0] low_sh_o,
  output logic              wrap_o
);
  localparam logic [STEP_W-1:0] STEP_LAST = '1;

  logic [STEP_W-1:0] step_q, low_sh;
  logic [DIV_W-1:0]  div_sh;

  assign wrap_o = tick_i && (step_q == STEP_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      div_sh <= '0;
      low_sh <= '0;
    end else if (clr_i) begin
      step_q <= '0;
      div_sh <= start_div_i;
      low_sh <= start_low_i;
    end else if (tick_i) begin
      step_q <= step_q + STEP_W'(1);
      if (wrap_o) begin
        div_sh <= live_div_i;
        low_sh <= live_low_i;
      end
    end
  end

  assign step_o   = step_q;
  assign div_sh_o = div_sh;
  assign low_sh_o = low_sh;
endmodule

// File: rtl/pwm_reg_gen.sv
module pwm_reg_gen
  import pwm_gen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [LANES-1:0]  wr_be_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              pwm_o
);
  cfg_t              cfg_q, cfg_d;
  logic              run_q, idle_q, clr, tick, wrap;
  logic [DIV_W-1:0]  presc, div_sh;
  logic [STEP_W-1:0] step, low_sh;

  pwm_cfg_reg i_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .wr_be_i,
    .cfg_q_o   (cfg_q),
    .cfg_d_o   (cfg_d),
    .rd_data_o (rd_data_o)
  );

  assign run_q  = cfg_q.run;
  assign idle_q = cfg_q.idle;
  // hold while off, restart on the edge that turns run on
  assign clr    = !cfg_d.run || !cfg_q.run;

  pwm_prescaler #(.DIV_W(DIV_W)) i_presc (
    .clk_i, .rst_ni,
    .clr_i  (clr),
    .div_i  (div_sh),
    .cnt_o  (presc),
    .tick_o (tick)
  );

  pwm_period_seq #(.STEP_W(STEP_W), .DIV_W(DIV_W)) i_seq (
    .clk_i, .rst_ni,
    .clr_i       (clr),
    .tick_i      (tick),
    .start_div_i (cfg_d.div),
    .start_low_i (cfg_d.low),
    .live_div_i  (cfg_q.div),
    .live_low_i  (cfg_q.low),
    .step_o      (step),
    .div_sh_o    (div_sh),
    .low_sh_o    (low_sh),
    .wrap_o      (wrap)
  );

  // driven from flops only, so no combinational path from the bus
  assign pwm_o = run_q ? (step >= low_sh) : idle_q;
endmodule

// File: rtl/pwm_reg_gen_chk.sv
module pwm_reg_gen_chk #(
  parameter int unsigned STEP_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              idle_i,
  input logic              pwm_i,
  input logic [31:0]       rd_i,
  input logic              wr_en_i,
  input logic [3:0]        be_i,
  input logic [STEP_W-1:0] step_i,
  input logic [DIV_W-1:0]  presc_i,
  input logic              tick_i,
  input logic              wrap_i,
  input logic [DIV_W-1:0]  div_sh_i,
  input logic [STEP_W-1:0] low_sh_i
);
  assert_idle_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> pwm_i == idle_i);

  assert_cnt_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (step_i == '0 && presc_i == '0));

  assert_presc_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> presc_i <= DIV_W'(div_sh_i - DIV_W'(1)));

  assert_step_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$past(tick_i)) |-> $stable(step_i));

  assert_shadow_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$past(wrap_i)) |-> ($stable(div_sh_i) && $stable(low_sh_i)));

  assert_ctrl_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && !be_i[3]) |-> $stable(rd_i[31:30]));
endmodule

bind pwm_reg_gen pwm_reg_gen_chk #(.STEP_W(pwm_gen_pkg::STEP_W), .DIV_W(pwm_gen_pkg::DIV_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run_q),
  .idle_i   (idle_q),
  .pwm_i    (pwm_o),
  .rd_i     (rd_data_o),
  .wr_en_i  (wr_en_i),
  .be_i     (wr_be_i),
  .step_i   (step),
  .presc_i  (presc),
  .tick_i   (tick),
  .wrap_i   (wrap),
  .div_sh_i (div_sh),
  .low_sh_i (low_sh)
);

// File: tb/test_pwm_reg_gen.sv
module test_pwm_reg_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] rd_data;
  logic        pwm;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_reg_gen i_pwm_reg_gen (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_be_i(wr_be), .rd_data_o(rd_data), .pwm_o(pwm)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference: first period uses (l0,n0), later ones (l1,n1); length 0 means 256
  function automatic logic ref_out(int c, int l0, int n0, int l1, int n1);
    int e0 = (l0 == 0) ? 256 : l0;
    int e1 = (l1 == 0) ? 256 : l1;
    int cc, n, e;
    if (c < 256*e0) begin cc = c; n = n0; e = e0; end
    else begin cc = (c - 256*e0) % (256*e1); n = n1; e = e1; end
    return ((cc / e) >= n);
  endfunction

  // called at a falling edge; returns at the falling edge after the capture edge
  task automatic bus_wr(input logic [31:0] d, input logic [3:0] be);
    wr_en = 1'b1; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic run_chk(input int n, input int l0, input int n0, input int l1, input int n1,
                         input int cw, input logic [31:0] wd, input logic [3:0] wbe,
                         input string req);
    for (int c = 0; c < n; c++) begin
      if (c == cw + 1) begin wr_en = 1'b0; wr_be = '0; end
      chk(pwm == ref_out(c, l0, n0, l1, n1), req, {31'd0, pwm}, {31'd0, ref_out(c, l0, n0, l1, n1)});
      if (c == cw) begin wr_en = 1'b1; wr_data = wd; wr_be = wbe; end
      @(negedge clk);
    end
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic restart(input logic [31:0] word);
    bus_wr(32'h0000_0000, 4'b1000);
    bus_wr(word, 4'b1111);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int l, n;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(rd_data == 32'h0, "R1 reset word", rd_data, 32'h0);
    chk(pwm == 1'b0, "R1 reset output", {31'd0, pwm}, 32'd0);

    // R3 idle level follows bit 30 while off
    bus_wr(32'h4000_0000, 4'b1000);
    chk(pwm == 1'b1, "R3 idle high", {31'd0, pwm}, 32'd1);
    bus_wr(32'h0000_0000, 4'b1000);
    chk(pwm == 1'b0, "R3 idle low", {31'd0, pwm}, 32'd0);

    // R2 reserved bits read zero
    bus_wr(32'h3FFF_FFFF, 4'b1111);
    chk(rd_data == 32'h0000_FFFF, "R2 reserved bits", rd_data, 32'h0000_FFFF);
    chk(pwm == 1'b0, "R3 off after full write", {31'd0, pwm}, 32'd0);

    // R5 R6 R4 basic run, length 1, low count 10
    restart(32'h8000_010A);
    run_chk(600, 1, 10, 1, 10, -1, '0, '0, "R5 length1 low10");

    // R7 low count change mid period
    restart(32'h8000_0114);
    run_chk(700, 1, 20, 1, 200, 100, 32'h0000_00C8, 4'b0001, "R7 low count update");
    chk(rd_data == 32'h8000_01C8, "R8 run kept on low-byte write", rd_data, 32'h8000_01C8);

    // R7 R4 step length change mid period
    restart(32'h8000_0240);
    run_chk(1600, 2, 64, 3, 64, 50, 32'h0000_0300, 4'b0010, "R7 length update");
    chk(rd_data == 32'h8000_0340, "R8 word after length write", rd_data, 32'h8000_0340);

    // R5 edge values of low count
    restart(32'h8000_0100);
    run_chk(300, 1, 0, 1, 0, -1, '0, '0, "R5 low count 0");
    restart(32'h8000_01FF);
    run_chk(520, 1, 255, 1, 255, -1, '0, '0, "R5 low count 255");

    // R4 length 0 means 256
    restart(32'h8000_0002);
    run_chk(65536 + 600, 0, 2, 0, 2, -1, '0, '0, "R4 length 0");

    // R3 R6 stop mid run, then restart
    restart(32'h8000_0105);
    run_chk(30, 1, 5, 1, 5, -1, '0, '0, "R6 pre-stop");
    bus_wr(32'h4000_0000, 4'b1000);
    for (int i = 0; i < 20; i++) begin
      chk(pwm == 1'b1, "R3 idle after stop", {31'd0, pwm}, 32'd1);
      @(negedge clk);
    end
    chk(rd_data == 32'h4000_0105, "R2 word after stop", rd_data, 32'h4000_0105);
    bus_wr(32'hC000_0000, 4'b1000);
    run_chk(300, 1, 5, 1, 5, -1, '0, '0, "R6 restart from step 0");

    // random runs
    for (int k = 0; k < 6; k++) begin
      l = 1 + int'($urandom % 3);
      n = int'($urandom % 256);
      restart({16'h8000, 8'(l), 8'(n)});
      run_chk(256*l + 40, l, n, l, n, -1, '0, '0, "R5 random run");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule